// File: doc/BRIEF.md
# Split-Byte Conversion Result Register

This block keeps the most recent 10-bit result from a converter and lets an 8-bit processor bus read it as two bytes. The conversion controller delivers each finished result with a one-cycle valid pulse. A left-adjust control bit selects how the 10 bits are placed across the 16-bit byte pair. The processor reads the pair one byte at a time, using a one-bit byte select.

A full-precision read takes the low byte first and then the high byte. Reading the low byte freezes the stored result, and reading the high byte unfreezes it. The two bytes of such a pair therefore always belong to the same conversion. A result that arrives while the register is frozen is dropped. If only 8 bits of precision are needed, software can set left-adjust and read the high byte alone. That access never freezes the register.

Top module: `conv_result_reg`

## Requirements
- R1: After reset the stored result is zero and the register is not frozen, so both bytes read 0x00.
- R2: With `left_adj` = 0, byte select 0 returns result bits 7:0, and byte select 1 returns result bits 9:8 in its bits 1:0, with bits 7:2 reading zero.
- R3: With `left_adj` = 1, byte select 1 returns result bits 9:2, and byte select 0 returns result bits 1:0 in its bits 7:6, with bits 5:0 reading zero.
- R4: While the register is not frozen, a `res_valid` pulse stores `res_data`, and the new value can be read from the cycle after the pulse.
- R5: A read strobe (`rd_en` = 1) with byte select 0 freezes the register from the next cycle on. Any `res_valid` pulse while the register is frozen leaves the stored result unchanged.
- R6: A read strobe with byte select 1 unfreezes the register. A result that arrived while the register was frozen is lost, and it does not appear after the register is unfrozen.
- R7: A `res_valid` pulse in the same cycle as a low-byte read strobe is discarded. That read returns the previous result, and the following high-byte read returns the previous result as well.
- R8: A change of `left_adj` changes `rd_data` in the same cycle, without a new conversion.
- R9: A read strobe with byte select 1 on a register that is not frozen leaves it unfrozen, so the next `res_valid` pulse is stored.
- R10: Selecting byte 0 with `rd_en` = 0 does not freeze the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | One-cycle pulse that marks a finished result |
| res_data | input | 10 | Result value, sampled when `res_valid` is high |
| left_adj | input | 1 | 1 = left-adjusted byte layout, 0 = right-adjusted |
| rd_en | input | 1 | Bus read strobe; it changes the freeze state |
| rd_addr | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| rd_data | output | 8 | Selected byte, combinational from the stored result |

## Verification
Two things can happen in the same cycle: a new result arriving and a bus read that changes the freeze state. The collision that matters is a `res_valid` pulse in the same clock cycle as the low-byte strobe. The bench drives both at once. It then checks that the low byte returned in that cycle, the high byte read next and a later plain look at the low byte all show the old value. The bench also delivers a result between the two reads of a pair, and a new result after the release. These cases show that a blocked result is dropped rather than held back and applied later.

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  input  logic              left_adj,
  input  logic              rd_en,
  input  logic              rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int PAIR_W = 2 * BYTE_W;
  localparam int SHIFT  = PAIR_W - RES_W;

  logic [RES_W-1:0]  res_q;
  logic              locked_q;
  logic              low_rd, high_rd, take;
  logic [PAIR_W-1:0] pair;

  assign low_rd  = rd_en & ~rd_addr;
  assign high_rd = rd_en & rd_addr;
  assign take    = res_valid & ~locked_q & ~low_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (take) res_q <= res_data;
      if (low_rd)       locked_q <= 1'b1;
      else if (high_rd) locked_q <= 1'b0;
    end
  end

  assign pair    = left_adj ? (PAIR_W'(res_q) << SHIFT) : PAIR_W'(res_q);
  assign rd_data = rd_addr ? pair[PAIR_W-1:BYTE_W] : pair[BYTE_W-1:0];
endmodule

module conv_result_reg_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [RES_W-1:0]  res_data,
  input logic              left_adj,
  input logic              rd_en,
  input logic              rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic [RES_W-1:0]  res_q,
  input logic              locked_q
);
  localparam int SHIFT = 2 * BYTE_W - RES_W;

  AST_RIGHT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!left_adj && rd_addr) |-> ((rd_data >> (RES_W - BYTE_W)) == '0)); // R2
  AST_LEFT_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (left_adj && !rd_addr) |-> (rd_data[SHIFT-1:0] == '0)); // R3
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !locked_q && !(rd_en && !rd_addr)) |=> (res_q == $past(res_data))); // R4
  AST_LOW_READ_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_addr) |=> locked_q); // R5
  AST_HOLD_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(res_q)); // R5
  AST_HIGH_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr) |=> !locked_q); // R6
  AST_COLLISION_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && rd_en && !rd_addr) |=> $stable(res_q)); // R7
  AST_NO_STROBE_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !locked_q) |=> !locked_q); // R10
endmodule

bind conv_result_reg conv_result_reg_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
  .left_adj(left_adj), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .res_q(res_q), .locked_q(locked_q)
);

// File: tb/test_conv_result_reg.sv
module test_conv_result_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic [9:0] res_data = '0;
  logic       left_adj = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_addr = 1'b0;
  logic [7:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  conv_result_reg i_conv_result_reg (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .left_adj(left_adj), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // {left_adj, data, expected low byte, expected high byte}
  localparam logic [26:0] VEC [0:6] = '{
    {1'b0, 10'h3FF, 8'hFF, 8'h03},
    {1'b0, 10'h2A5, 8'hA5, 8'h02},
    {1'b1, 10'h3FF, 8'hC0, 8'hFF},
    {1'b1, 10'h2A5, 8'h40, 8'hA9},
    {1'b0, 10'h000, 8'h00, 8'h00},
    {1'b1, 10'h155, 8'h40, 8'h55},
    {1'b0, 10'h155, 8'h55, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [9:0] d);
    res_valid = 1'b1; res_data = d;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    rd_en = 1'b1; rd_addr = a;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(1'b0, v); check("R1 low after reset", v, 8'h00);
    peek(1'b1, v); check("R1 high after reset", v, 8'h00);

    for (int i = 0; i < 7; i++) begin
      left_adj = VEC[i][26];
      pulse(VEC[i][25:16]);
      rd(1'b0, v); check(VEC[i][26] ? "R3 R4 low byte" : "R2 R4 low byte", v, VEC[i][15:8]);
      rd(1'b1, v); check(VEC[i][26] ? "R3 high byte" : "R2 high byte", v, VEC[i][7:0]);
    end

    left_adj = 1'b0;
    pulse(10'h123);
    rd(1'b0, v); check("R5 low byte", v, 8'h23);
    pulse(10'h3C0);
    peek(1'b0, v); check("R5 blocked update", v, 8'h23);
    rd(1'b1, v); check("R5 coherent high byte", v, 8'h01);
    peek(1'b0, v); check("R6 dropped not queued", v, 8'h23);
    pulse(10'h0F0);
    peek(1'b0, v); check("R6 update after release", v, 8'hF0);

    pulse(10'h0AA);
    res_valid = 1'b1; res_data = 10'h355; rd_en = 1'b1; rd_addr = 1'b0;
    #1 v = rd_data;
    check("R7 collision low byte", v, 8'hAA);
    @(negedge clk);
    res_valid = 1'b0; rd_en = 1'b0;
    rd(1'b1, v); check("R7 collision high byte", v, 8'h00);
    peek(1'b0, v); check("R7 collision value dropped", v, 8'hAA);

    pulse(10'h2A5);
    peek(1'b1, v); check("R8 right high", v, 8'h02);
    left_adj = 1'b1;
    peek(1'b1, v); check("R8 left high without conversion", v, 8'hA9);
    peek(1'b0, v); check("R8 left low without conversion", v, 8'h40);

    rd(1'b1, v); check("R9 high-only read", v, 8'hA9);
    pulse(10'h3FF);
    peek(1'b1, v); check("R9 not frozen by high read", v, 8'hFF);

    left_adj = 1'b0;
    peek(1'b0, v);
    @(negedge clk);
    pulse(10'h07E);
    peek(1'b0, v); check("R10 no strobe no freeze", v, 8'h7E);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule